// File: doc/BRIEF.md
# Trimmed Field Threshold Switch

This block turns a stream of signed field samples into a single switch flag. Each sample arrives with a one-cycle strobe. The block compares the sample against an operate point that is set by a trim code. The flag is driven low (active) once the field reaches the operate point. It is driven high (inactive) once the field drops below a release point. The release point sits a constant hysteresis distance beneath the operate point.

The trim is given in sign-magnitude form: a 7-bit magnitude and a sign bit. The operate point is a base value plus a step multiplied by the signed code, which spans -127 to +127. The result is clamped to the sample range. The sign bit only moves the threshold; it never changes which way the output switches.

From reset, the flag holds a defined high state. It stays high until a start-up window, counted in sample strobes, has passed. Samples that arrive inside that window are discarded. The first sample after the window is judged with "high" as its history. A field inside the hysteresis band therefore leaves the output high.

Top module: `hall_thresh_switch`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `sw_out` is 1 and `out_ready` is 0.
- R2: The first POR_SAMPLES strobes after reset (default 13) are discarded: `sw_out` stays 1 for any field value.
- R3: `out_ready` rises in the cycle after the POR_SAMPLES-th strobe and then stays 1 until reset.
- R4: The operate point is BASE + STEP×c, where c = +trim_mag when trim_neg is 0 and c = -trim_mag when trim_neg is 1. Defaults are BASE = 400 and STEP = 8. The release point is the operate point minus HYST (default 60), clamped to the 12-bit signed range.
- R5: When `sw_out` is 1, a strobed sample with field ≥ operate point drives `sw_out` to 0 on the next cycle. The boundary case, field equal to the operate point, also switches.
- R6: When `sw_out` is 0, a strobed sample with field < release point drives `sw_out` to 1 on the next cycle. A field equal to the release point, or anywhere between the two points, leaves the output unchanged.
- R7: `sw_out` changes only in the cycle after a strobe. Field values presented without a strobe have no effect.
- R8: With trim_neg = 1, reaching the operate point still drives `sw_out` to 0. Falling below the release point still drives it to 1. The polarity bit never inverts the output.
- R9: The first evaluated sample after the start-up window takes "high" as its prior state. A field inside the hysteresis band therefore keeps `sw_out` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | One-cycle strobe marking a new field sample |
| smp_field | input | 12 | Signed field sample (two's complement) |
| trim_mag | input | 7 | Trim code magnitude, 0 to 127 |
| trim_neg | input | 1 | Trim code sign: 1 makes the code negative |
| sw_out | output | 1 | Switch flag: 0 = operate (tooth), 1 = released |
| out_ready | output | 1 | 1 once the start-up window has passed |

## Verification
The assertions assume that the trim inputs are held steady across any strobe they affect. They also assume the strobe is a level sampled on each rising edge and is never interpreted as an edge. The bench changes the trim only when no strobe is pending. It drives every input on the falling clock edge, and it keeps random fields inside ±1500 so that no threshold is clamped. Directed samples land exactly on the operate and release points, one count below each, and inside the band on the first evaluated sample.

// File: rtl/thr_switch_pkg.sv
package thr_switch_pkg;

    typedef enum logic {
        SW_OPERATE = 1'b0,
        SW_RELEASE = 1'b1
    } sw_state_e;

    typedef struct packed {
        int op_pt;
        int rel_pt;
    } thr_pair_t;

    function automatic int clamp_int(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic int signed_code(input int mag, input logic neg);
        return neg ? -mag : mag;
    endfunction

endpackage

// File: rtl/thr_calc.sv
module thr_calc
    import thr_switch_pkg::*;
#(
    parameter int CODE_W = 7,
    parameter int BASE   = 400,
    parameter int STEP   = 8,
    parameter int HYST   = 60,
    parameter int LO     = -2048,
    parameter int HI     = 2047
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] trim_mag,
    input  logic              trim_neg,
    output thr_pair_t         thr
);

    int code_s;
    int raw_op;
    int op_c;

    always_comb begin
        code_s     = signed_code(int'(trim_mag), trim_neg);
        raw_op     = BASE + STEP * code_s;
        op_c       = clamp_int(raw_op, LO, HI);
        thr.op_pt  = op_c;
        thr.rel_pt = clamp_int(op_c - HYST, LO, HI);
    end

    // R4: release point never sits above the operate point
    p_rel_below_op_r4: assert property (@(posedge clk) disable iff (rst)
        thr.rel_pt <= thr.op_pt);

    // R4: both points stay inside the sample range
    p_in_range_r4: assert property (@(posedge clk) disable iff (rst)
        thr.op_pt >= LO && thr.op_pt <= HI && thr.rel_pt >= LO);

endmodule

// File: rtl/por_gate.sv
module por_gate #(
    parameter int POR_SAMPLES = 13,
    localparam int CNT_W = $clog2(POR_SAMPLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic smp_valid,
    output logic ready
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(POR_SAMPLES);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (smp_valid && cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign ready = (cnt == LIMIT);

    // R3: once ready, stays ready until reset
    p_ready_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    // R3: ready only rises right after a strobe
    p_ready_after_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        (!ready && !smp_valid) |=> !ready);

endmodule

// File: rtl/hyst_cmp.sv
module hyst_cmp
    import thr_switch_pkg::*;
#(
    parameter int FIELD_W = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      smp_valid,
    input  logic                      ready,
    input  logic signed [FIELD_W-1:0] field,
    input  thr_pair_t                 thr,
    output logic                      sw_out
);

    sw_state_e state;
    int        field_x;
    logic      at_op;
    logic      below_rel;
    logic      judge;

    always_comb begin
        field_x   = int'(field);
        at_op     = field_x >= thr.op_pt;
        below_rel = field_x < thr.rel_pt;
        judge     = smp_valid && ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SW_RELEASE;
        end else if (judge) begin
            case (state)
                SW_RELEASE: if (at_op)     state <= SW_OPERATE;
                SW_OPERATE: if (below_rel) state <= SW_RELEASE;
                default:                   state <= SW_RELEASE;
            endcase
        end
    end

    assign sw_out = (state == SW_RELEASE);

    // R2: output held released until the start-up window ends
    p_por_high_r2: assert property (@(posedge clk) disable iff (rst)
        !ready |-> sw_out);

    // R7: no strobe, no change
    p_no_strobe_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(sw_out));

    // R5: reaching the operate point switches low
    p_operate_r5: assert property (@(posedge clk) disable iff (rst)
        (judge && field_x >= thr.op_pt) |=> !sw_out);

    // R6: falling below the release point switches high
    p_release_r6: assert property (@(posedge clk) disable iff (rst)
        (judge && field_x < thr.rel_pt) |=> sw_out);

    // R6: inside the band the output holds
    p_band_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (judge && field_x >= thr.rel_pt && field_x < thr.op_pt) |=> $stable(sw_out));

endmodule

// File: rtl/hall_thresh_switch.sv
module hall_thresh_switch
    import thr_switch_pkg::*;
#(
    parameter int FIELD_W     = 12,
    parameter int CODE_W      = 7,
    parameter int BASE        = 400,
    parameter int STEP        = 8,
    parameter int HYST        = 60,
    parameter int POR_SAMPLES = 13
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      smp_valid,
    input  logic signed [FIELD_W-1:0] smp_field,
    input  logic [CODE_W-1:0]         trim_mag,
    input  logic                      trim_neg,
    output logic                      sw_out,
    output logic                      out_ready
);

    localparam int FIELD_LO = -(2 ** (FIELD_W - 1));
    localparam int FIELD_HI = (2 ** (FIELD_W - 1)) - 1;

    thr_pair_t thr;
    logic      ready;

    thr_calc #(
        .CODE_W (CODE_W),
        .BASE   (BASE),
        .STEP   (STEP),
        .HYST   (HYST),
        .LO     (FIELD_LO),
        .HI     (FIELD_HI)
    ) u_thr (
        .clk      (clk),
        .rst      (rst),
        .trim_mag (trim_mag),
        .trim_neg (trim_neg),
        .thr      (thr)
    );

    por_gate #(
        .POR_SAMPLES (POR_SAMPLES)
    ) u_por (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .ready     (ready)
    );

    hyst_cmp #(
        .FIELD_W (FIELD_W)
    ) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .ready     (ready),
        .field     (smp_field),
        .thr       (thr),
        .sw_out    (sw_out)
    );

    assign out_ready = ready;

    // R1: after reset release the flag is high and not ready
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (sw_out && !out_ready));

endmodule

// File: tb/hall_thresh_switch_test.sv
module hall_thresh_switch_test;

    localparam int BASE = 400;
    localparam int STEP = 8;
    localparam int HYST = 60;
    localparam int NPOR = 13;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              smp_valid = 1'b0;
    logic signed [11:0] smp_field = '0;
    logic [6:0]        trim_mag = '0;
    logic              trim_neg = 1'b0;
    logic              sw_out;
    logic              out_ready;

    int n_run  = 0;
    int n_fail = 0;
    logic ref_out = 1'b1;

    always #10 clk = ~clk;

    hall_thresh_switch uut (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_field (smp_field),
        .trim_mag  (trim_mag),
        .trim_neg  (trim_neg),
        .sw_out    (sw_out),
        .out_ready (out_ready)
    );

    function automatic int exp_op(input int mag, input logic neg);
        return BASE + STEP * (neg ? -mag : mag);
    endfunction

    function automatic int exp_rel(input int mag, input logic neg);
        return exp_op(mag, neg) - HYST;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic strobe(input int f);
        smp_valid = 1'b1;
        smp_field = 12'(f);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic model(input int f);
        int op;
        int rl;
        op = exp_op(int'(trim_mag), trim_neg);
        rl = exp_rel(int'(trim_mag), trim_neg);
        if (ref_out && f >= op) ref_out = 1'b0;
        else if (!ref_out && f < rl) ref_out = 1'b1;
    endtask

    initial begin
        #3_000_000;
        n_fail++;
        $display("FAIL watchdog: got hang expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R1 reset flag", sw_out, 1'b1);
        check("R1 reset ready", out_ready, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release flag", sw_out, 1'b1);
        check("R1 after release ready", out_ready, 1'b0);

        // R2: start-up strobes with strong field are discarded
        for (int i = 0; i < NPOR; i++) begin
            if (i == NPOR - 1) check("R3 not ready before last", out_ready, 1'b0);
            strobe(2000);
            check("R2 held high in window", sw_out, 1'b1);
        end
        check("R3 ready after window", out_ready, 1'b1);

        // R9: first evaluated sample inside band (op=400, rel=340)
        strobe(370);
        check("R9 band on first sample", sw_out, 1'b1);

        // R5: exactly at operate point
        strobe(400);
        check("R5 equal to op", sw_out, 1'b0);

        // R7: no strobe, extreme field
        smp_field = -12'sd2000;
        repeat (4) @(negedge clk);
        check("R7 no strobe ignored", sw_out, 1'b0);

        // R6: at release point holds, one below releases
        strobe(340);
        check("R6 equal to rel holds", sw_out, 1'b0);
        strobe(339);
        check("R6 below rel releases", sw_out, 1'b1);
        strobe(399);
        check("R5 one below op holds", sw_out, 1'b1);

        // R4: positive code 5 -> op 440
        trim_mag = 7'd5;
        @(negedge clk);
        strobe(439);
        check("R4 code+5 below op", sw_out, 1'b1);
        strobe(440);
        check("R4 code+5 at op", sw_out, 1'b0);
        strobe(380);
        check("R4 code+5 at rel", sw_out, 1'b0);
        strobe(379);
        check("R4 code+5 below rel", sw_out, 1'b1);

        // R8: negative code -127 -> op -616, rel -676
        trim_mag = 7'd127;
        trim_neg = 1'b1;
        @(negedge clk);
        strobe(-617);
        check("R8 neg below op", sw_out, 1'b1);
        strobe(-616);
        check("R8 neg at op switches low", sw_out, 1'b0);
        strobe(-676);
        check("R8 neg at rel holds", sw_out, 1'b0);
        strobe(-677);
        check("R8 neg below rel releases", sw_out, 1'b1);

        // R3: ready still held
        check("R3 ready sticky", out_ready, 1'b1);

        // Random phase (R4 R5 R6 R7)
        ref_out = sw_out;
        for (int k = 0; k < 600; k++) begin
            int f;
            if (k % 25 == 0) begin
                trim_mag = 7'($urandom_range(0, 127));
                trim_neg = 1'($urandom_range(0, 1));
                @(negedge clk);
            end
            f = int'($urandom_range(0, 3000)) - 1500;
            if ($urandom_range(0, 3) == 0) begin
                smp_field = 12'(f);
                @(negedge clk);
                check("R7 random idle", sw_out, ref_out);
            end else begin
                model(f);
                strobe(f);
                check("R5/R6 random R4 thresholds", sw_out, ref_out);
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule